// File: doc/BRIEF.md
# Address-Window Access Filter for a Multi-Port Memory Controller

This block stands in front of a multi-port SDRAM controller and decides, one request at a time, whether an access may proceed. It keeps a table of 20 protection rules. Each rule describes an address window with 1 MiB granularity, an inclusive range of requester IDs, which security states it applies to, and which ports it covers. It also carries a valid bit and a verdict that either admits or refuses the access. A per-port default mask settles every access that no rule covers.

Software never writes the rule table directly. It fills three staging words, names a rule in the command register, and then sets either the commit bit, which copies the staged words into that rule, or the load bit, which copies that rule back into the staging words so they can be read. Each request carries a port number, a 32-bit address, a 12-bit requester ID and a non-secure flag. The request is taken on a valid/ready handshake, and the verdict is registered, so it appears one clock later.

Top module: `mem_prot_filter`

## Requirements
- R1: After reset, every rule is invalid and the default mask and all staging words read zero, so every request on a port below 10 is admitted.
- R2: Register select codes are: 0 command, 1 address staging, 2 ID staging, 3 data staging, 4 default mask. Address staging holds the low window in bits 11:0 and the high window in bits 23:12, each compared with address bits 31:20. ID staging holds the low ID in bits 11:0 and the high ID in bits 23:12. Data staging holds security in bits 1:0, valid in bit 2, the port mask in bits 12:3 and the verdict in bit 13 (0 admits, 1 refuses). The default mask is 10 bits. Reading code 0 returns the last written rule number in bits 4:0. Unused bits and unused codes read as zero.
- R3: A write to the command register with rule number n below 20 commits the staging words into rule n when bit 5 is set. When bit 6 is set and bit 5 is clear, it loads rule n into the staging words. When both bits are set, the commit is done and the load is not. A command naming a rule of 20 or above changes neither the table nor the staging words.
- R4: A rule matches a request when all of the following hold: the rule is valid; the port's bit is set in its port mask; address bits 31:20 lie within [low, high], both bounds included; the ID lies within [low ID, high ID], both bounds included; and the security field permits the request. Security bit 0 permits secure requests (flag 0) and bit 1 permits non-secure requests (flag 1).
- R5: When more than one rule matches, the lowest-numbered matching rule decides the verdict.
- R6: When no rule matches, the port's default-mask bit decides: 1 refuses and 0 admits.
- R7: A request on a port number of 10 or above is always refused.
- R8: `dec_valid` rises for exactly one clock in the cycle after each accepted handshake (`req_valid` and `req_ready` both high), and `dec_accept` carries the verdict in that same cycle.
- R9: `req_ready` is low in a cycle where a commit to a rule below 20 is being written, and high in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| req_valid | input | 1 | Request presented |
| req_ready | output | 1 | Request can be taken this cycle |
| req_port | input | 4 | Requesting port number |
| req_addr | input | 32 | Byte address of the access |
| req_id | input | 12 | Requester ID |
| req_nonsec | input | 1 | 1 for a non-secure request |
| dec_valid | output | 1 | Verdict valid |
| dec_accept | output | 1 | 1 admits, 0 refuses |

## Verification
Directed requests sit exactly on the window and ID bounds and one step past them. This tells inclusive compares apart from exclusive or off-by-one ones. Other directed requests land where two rules overlap, which shows whether the lowest rule number really wins. Ports that no rule covers show whether the default mask or a stale rule decides, and the security flag is tried against single-state rules. A long pseudo-random phase mixes requests with staging writes, commits, loads and out-of-range rule numbers in the same cycles. A behavioural table model predicts every verdict, every ready value and every read-back word.

// File: rtl/mpg_pkg.sv
package mpg_pkg;
    localparam int NUM_RULES      = 20;
    localparam int NUM_PORTS      = 10;
    localparam int WIN_W          = 12;
    localparam int ID_W           = 12;
    localparam int SEC_W          = 2;
    localparam int PORT_W         = 4;
    localparam int ADDR_W         = 32;
    localparam int WIN_LSB        = ADDR_W - WIN_W;
    localparam int CFG_SEL_W      = 3;
    localparam int DATA_W         = 32;
    localparam int CMD_COMMIT_BIT = 5;
    localparam int CMD_LOAD_BIT   = 6;
    localparam int PM_LSB         = SEC_W + 1;
    localparam int VERDICT_BIT    = PM_LSB + NUM_PORTS;

    typedef enum logic [CFG_SEL_W-1:0] {
        REG_CMD  = 3'd0,
        REG_ADDR = 3'd1,
        REG_ID   = 3'd2,
        REG_DATA = 3'd3,
        REG_DFLT = 3'd4
    } cfg_reg_e;

    // Field order mirrors the staging word layouts.
    typedef struct packed {
        logic [WIN_W-1:0]     win_hi;
        logic [WIN_W-1:0]     win_lo;
        logic [ID_W-1:0]      id_hi;
        logic [ID_W-1:0]      id_lo;
        logic                 reject;
        logic [NUM_PORTS-1:0] pmask;
        logic                 valid;
        logic [SEC_W-1:0]     sec;
    } rule_t;

    function automatic logic [DATA_W-1:0] addr_word(rule_t r);
        return DATA_W'({r.win_hi, r.win_lo});
    endfunction

    function automatic logic [DATA_W-1:0] id_word(rule_t r);
        return DATA_W'({r.id_hi, r.id_lo});
    endfunction

    function automatic logic [DATA_W-1:0] data_word(rule_t r);
        return DATA_W'({r.reject, r.pmask, r.valid, r.sec});
    endfunction
endpackage

// File: rtl/mpg_rule_table.sv
module mpg_rule_table
    import mpg_pkg::*;
#(
    parameter int N_RULES = NUM_RULES
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_wr_en,
    input  logic [CFG_SEL_W-1:0]       cfg_sel,
    input  logic [DATA_W-1:0]          cfg_wdata,
    output logic [DATA_W-1:0]          cfg_rdata,
    output rule_t [N_RULES-1:0]        rules_o,
    output logic [NUM_PORTS-1:0]       dflt_o,
    output logic                       commit_o
);
    localparam int IW = $clog2(N_RULES);

    rule_t [N_RULES-1:0]   rules_q;
    rule_t                 stage_q;
    rule_t                 load_rule;
    logic [IW-1:0]         sel_q;
    logic [IW-1:0]         idx;
    logic [NUM_PORTS-1:0]  dflt_q;
    logic                  cmd_wr, idx_ok, commit, load;

    assign idx    = cfg_wdata[IW-1:0];
    assign idx_ok = int'(idx) < N_RULES;
    assign cmd_wr = cfg_wr_en && (cfg_sel == REG_CMD);
    assign commit = cmd_wr && cfg_wdata[CMD_COMMIT_BIT] && idx_ok;
    assign load   = cmd_wr && cfg_wdata[CMD_LOAD_BIT] && !cfg_wdata[CMD_COMMIT_BIT] && idx_ok;

    always_comb begin
        load_rule = '0;
        for (int r = 0; r < N_RULES; r++)
            if (idx == IW'(r)) load_rule = rules_q[r];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rules_q <= '0;
            stage_q <= '0;
            sel_q   <= '0;
            dflt_q  <= '0;
        end else if (cfg_wr_en) begin
            case (cfg_sel)
                REG_CMD: begin
                    sel_q <= idx;
                    if (load) stage_q <= load_rule;
                    for (int r = 0; r < N_RULES; r++)
                        if (commit && idx == IW'(r)) rules_q[r] <= stage_q;
                end
                REG_ADDR: {stage_q.win_hi, stage_q.win_lo} <= cfg_wdata[2*WIN_W-1:0];
                REG_ID:   {stage_q.id_hi, stage_q.id_lo}   <= cfg_wdata[2*ID_W-1:0];
                REG_DATA: begin
                    stage_q.sec    <= cfg_wdata[SEC_W-1:0];
                    stage_q.valid  <= cfg_wdata[SEC_W];
                    stage_q.pmask  <= cfg_wdata[PM_LSB +: NUM_PORTS];
                    stage_q.reject <= cfg_wdata[VERDICT_BIT];
                end
                REG_DFLT: dflt_q <= cfg_wdata[NUM_PORTS-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (cfg_sel)
            REG_CMD:  cfg_rdata = DATA_W'(sel_q);
            REG_ADDR: cfg_rdata = addr_word(stage_q);
            REG_ID:   cfg_rdata = id_word(stage_q);
            REG_DATA: cfg_rdata = data_word(stage_q);
            REG_DFLT: cfg_rdata = DATA_W'(dflt_q);
            default:  cfg_rdata = '0;
        endcase
    end

    assign rules_o  = rules_q;
    assign dflt_o   = dflt_q;
    assign commit_o = commit;

    for (genvar g = 0; g < N_RULES; g++) begin : g_chk
        // R3: a commit lands the staged words in the named rule
        assert_commit_R3: assert property (@(posedge clk) disable iff (rst)
            (commit && idx == IW'(g)) |=> rules_q[g] == $past(stage_q));
        // R3: a load brings the named rule back into staging
        assert_load_R3: assert property (@(posedge clk) disable iff (rst)
            (load && idx == IW'(g)) |=> stage_q == $past(rules_q[g]));
    end

    assert_bad_index_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !idx_ok) |=> ($stable(rules_q) && $stable(stage_q)));

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dflt_q == '0 && stage_q == '0));
endmodule

// File: rtl/mpg_match.sv
module mpg_match
    import mpg_pkg::*;
#(
    parameter int N_RULES = NUM_RULES
) (
    input  rule_t [N_RULES-1:0]  rules_i,
    input  logic [PORT_W-1:0]    req_port,
    input  logic [WIN_W-1:0]     req_win,
    input  logic [ID_W-1:0]      req_id,
    input  logic                 req_nonsec,
    output logic [N_RULES-1:0]   hit_vec
);
    logic port_ok;
    assign port_ok = int'(req_port) < NUM_PORTS;

    for (genvar g = 0; g < N_RULES; g++) begin : g_rule
        logic in_win, in_id, port_hit, sec_ok;
        assign in_win   = (req_win >= rules_i[g].win_lo) && (req_win <= rules_i[g].win_hi);
        assign in_id    = (req_id >= rules_i[g].id_lo) && (req_id <= rules_i[g].id_hi);
        assign port_hit = port_ok && rules_i[g].pmask[req_port];
        assign sec_ok   = rules_i[g].sec[req_nonsec];
        assign hit_vec[g] = rules_i[g].valid && port_hit && in_win && in_id && sec_ok;
    end
endmodule

// File: rtl/mpg_decide.sv
module mpg_decide
    import mpg_pkg::*;
#(
    parameter int N_RULES = NUM_RULES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fire,
    input  logic [N_RULES-1:0]    hit_vec,
    input  rule_t [N_RULES-1:0]   rules_i,
    input  logic [NUM_PORTS-1:0]  dflt_i,
    input  logic [PORT_W-1:0]     req_port,
    output logic                  dec_valid,
    output logic                  dec_accept
);
    logic found, rej, port_ok, dflt_bit, accept_d;

    always_comb begin
        found = 1'b0;
        rej   = 1'b0;
        for (int r = N_RULES - 1; r >= 0; r--) begin
            if (hit_vec[r]) begin
                found = 1'b1;
                rej   = rules_i[r].reject;
            end
        end
        port_ok  = int'(req_port) < NUM_PORTS;
        dflt_bit = port_ok ? dflt_i[req_port] : 1'b1;
        accept_d = port_ok && (found ? !rej : !dflt_bit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_valid  <= fire;
            dec_accept <= fire && accept_d;
        end
    end

    assert_first_rule_R5: assert property (@(posedge clk) disable iff (rst)
        (fire && hit_vec[0]) |=> (dec_accept == !$past(rules_i[0].reject)));

    assert_default_R6: assert property (@(posedge clk) disable iff (rst)
        (fire && port_ok && hit_vec == '0) |=> (dec_accept == !$past(dflt_bit)));

    assert_bad_port_R7: assert property (@(posedge clk) disable iff (rst)
        (fire && !port_ok) |=> (dec_valid && !dec_accept));
endmodule

// File: rtl/mem_prot_filter.sv
module mem_prot_filter
    import mpg_pkg::*;
#(
    parameter int N_RULES = NUM_RULES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr_en,
    input  logic [CFG_SEL_W-1:0] cfg_sel,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [PORT_W-1:0]    req_port,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [ID_W-1:0]      req_id,
    input  logic                 req_nonsec,
    output logic                 dec_valid,
    output logic                 dec_accept
);
    rule_t [N_RULES-1:0]   rules;
    logic [NUM_PORTS-1:0]  dflt;
    logic [N_RULES-1:0]    hit_vec;
    logic                  commit, fire;

    mpg_rule_table #(.N_RULES(N_RULES)) u_table (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rules_o(rules),
        .dflt_o(dflt), .commit_o(commit)
    );

    mpg_match #(.N_RULES(N_RULES)) u_match (
        .rules_i(rules), .req_port(req_port), .req_win(req_addr[ADDR_W-1:WIN_LSB]),
        .req_id(req_id), .req_nonsec(req_nonsec), .hit_vec(hit_vec)
    );

    assign req_ready = !commit;
    assign fire      = req_valid && req_ready;

    mpg_decide #(.N_RULES(N_RULES)) u_decide (
        .clk(clk), .rst(rst), .fire(fire), .hit_vec(hit_vec), .rules_i(rules),
        .dflt_i(dflt), .req_port(req_port), .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    assert_handshake_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> dec_valid);

    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !dec_valid);
endmodule

// File: tb/mem_prot_filter_bench.sv
`timescale 1ns/1ps
module mem_prot_filter_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wr_en = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [3:0] req_port = '0;
    logic [31:0] req_addr = '0;
    logic [11:0] req_id = '0;
    logic req_nonsec = 1'b0;
    logic dec_valid, dec_accept;

    always #2 clk = ~clk;

    mem_prot_filter u_mem_prot_filter (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_port(req_port), .req_addr(req_addr),
        .req_id(req_id), .req_nonsec(req_nonsec), .dec_valid(dec_valid),
        .dec_accept(dec_accept)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0, started = 0;

    // behavioural table model
    int m_lo[20], m_hi[20], m_il[20], m_ih[20], m_sec[20], m_val[20], m_pm[20], m_rej[20];
    int s_lo, s_hi, s_il, s_ih, s_sec, s_val, s_pm, s_rej;
    int m_sel, m_dflt;
    bit exp_dv;
    bit exp_acc;
    string exp_tag;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_read(int sel);
        case (sel)
            0: return m_sel;
            1: return (s_hi << 12) | s_lo;
            2: return (s_ih << 12) | s_il;
            3: return (s_rej << 13) | (s_pm << 3) | (s_val << 2) | s_sec;
            4: return m_dflt;
            default: return 0;
        endcase
    endfunction

    function automatic bit model_decide(int port, int win, int id, int ns, output string tag);
        bit any_valid = 0;
        if (port >= 10) begin tag = "R7"; return 0; end
        for (int r = 0; r < 20; r++) begin
            if (m_val[r] != 0) any_valid = 1;
            if (m_val[r] != 0 && ((m_pm[r] >> port) & 1) != 0 && win >= m_lo[r] && win <= m_hi[r]
                && id >= m_il[r] && id <= m_ih[r] && ((m_sec[r] >> ns) & 1) != 0) begin
                tag = "R4 R5";
                return m_rej[r] == 0;
            end
        end
        tag = (!any_valid && m_dflt == 0) ? "R1 R6" : "R6";
        return ((m_dflt >> port) & 1) == 0;
    endfunction

    task automatic model_reset();
        for (int r = 0; r < 20; r++) begin
            m_lo[r] = 0; m_hi[r] = 0; m_il[r] = 0; m_ih[r] = 0;
            m_sec[r] = 0; m_val[r] = 0; m_pm[r] = 0; m_rej[r] = 0;
        end
        s_lo = 0; s_hi = 0; s_il = 0; s_ih = 0; s_sec = 0; s_val = 0; s_pm = 0; s_rej = 0;
        m_sel = 0; m_dflt = 0;
    endtask

    // compare one settling point before every rising edge, then advance the model
    initial begin
        forever begin
            int w, n;
            bit commit_now, exp_ready;
            @(negedge clk);
            #1;
            w = int'(cfg_wdata);
            n = w & 31;
            commit_now = cfg_wr_en && cfg_sel == 3'd0 && ((w >> 5) & 1) != 0 && n < 20;
            exp_ready = !commit_now;
            if (started) begin
                chk("R9 req_ready", 32'(req_ready), 32'(exp_ready));
                chk("R2 R3 cfg_rdata", cfg_rdata, 32'(model_read(int'(cfg_sel))));
                chk("R8 dec_valid", 32'(dec_valid), 32'(exp_dv));
                if (exp_dv) chk({exp_tag, " dec_accept"}, 32'(dec_accept), 32'(exp_acc));
            end
            if (rst) begin
                model_reset();
                exp_dv = 0;
                started = 1;
            end else begin
                exp_dv = req_valid && exp_ready;
                if (exp_dv)
                    exp_acc = model_decide(int'(req_port), int'(req_addr[31:20]), int'(req_id),
                                           int'(req_nonsec), exp_tag);
                if (cfg_wr_en) begin
                    case (cfg_sel)
                        3'd0: begin
                            m_sel = n;
                            if (commit_now) begin
                                m_lo[n] = s_lo; m_hi[n] = s_hi; m_il[n] = s_il; m_ih[n] = s_ih;
                                m_sec[n] = s_sec; m_val[n] = s_val; m_pm[n] = s_pm; m_rej[n] = s_rej;
                            end else if (((w >> 6) & 1) != 0 && n < 20) begin
                                s_lo = m_lo[n]; s_hi = m_hi[n]; s_il = m_il[n]; s_ih = m_ih[n];
                                s_sec = m_sec[n]; s_val = m_val[n]; s_pm = m_pm[n]; s_rej = m_rej[n];
                            end
                        end
                        3'd1: begin s_lo = w & 'hFFF; s_hi = (w >> 12) & 'hFFF; end
                        3'd2: begin s_il = w & 'hFFF; s_ih = (w >> 12) & 'hFFF; end
                        3'd3: begin
                            s_sec = w & 3; s_val = (w >> 2) & 1;
                            s_pm = (w >> 3) & 'h3FF; s_rej = (w >> 13) & 1;
                        end
                        3'd4: m_dflt = w & 'h3FF;
                        default: ;
                    endcase
                end
            end
        end
    end

    task automatic drv(bit wr, int sel, int wd, bit rv, int port, logic [31:0] addr, int id, bit ns);
        @(negedge clk);
        cfg_wr_en = wr; cfg_sel = 3'(sel); cfg_wdata = 32'(wd);
        req_valid = rv; req_port = 4'(port); req_addr = addr; req_id = 12'(id); req_nonsec = ns;
    endtask

    task automatic wr_reg(int sel, int val);
        drv(1, sel, val, 0, 0, 0, 0, 0);
    endtask

    task automatic rd_reg(int sel);
        drv(0, sel, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic req(int port, logic [31:0] addr, int id, bit ns);
        drv(0, 0, 0, 1, port, addr, id, ns);
    endtask

    task automatic prog(int idx, int lo, int hi, int il, int ih, int sec, int pm, int rej);
        wr_reg(1, (hi << 12) | lo);
        wr_reg(2, (ih << 12) | il);
        wr_reg(3, (rej << 13) | (pm << 3) | (1 << 2) | sec);
        wr_reg(0, idx | (1 << 5));
    endtask

    initial begin
        repeat (3) drv(0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk); rst = 1'b0;
        // R1: fresh table admits everything on valid ports; R7 refuses port 12
        req(0, 32'h0000_0000, 0, 0);
        req(9, 32'hFFFF_FFFF, 'hFFF, 1);
        req(12, 32'h0000_0000, 0, 0);
        for (int s = 0; s < 8; s++) rd_reg(s);
        // R4 R5: overlapping rules, tight bounds, single-state security
        prog(5, 'h100, 'h1FF, 'h010, 'h020, 1, 'h00C, 1);
        prog(2, 'h180, 'h180, 'h000, 'hFFF, 3, 'h3FF, 0);
        prog(19, 'h000, 'hFFF, 'h000, 'hFFF, 2, 'h080, 1);
        wr_reg(4, 'h3F0);
        req(2, 32'h1000_0000, 'h010, 0);
        req(2, 32'h1FFF_FFFF, 'h020, 0);
        req(2, 32'h2000_0000, 'h010, 0);
        req(2, 32'h0FFF_FFFF, 'h010, 0);
        req(2, 32'h1400_0000, 'h021, 0);
        req(2, 32'h1400_0000, 'h00F, 0);
        req(2, 32'h1400_0000, 'h015, 1);
        req(3, 32'h1800_0000, 'h015, 0);
        req(3, 32'h1810_0000, 'h015, 0);
        req(4, 32'h1800_0000, 'h300, 1);
        req(4, 32'h0000_0000, 'h000, 0);
        req(7, 32'h0000_0000, 'h000, 1);
        req(1, 32'h0000_0000, 'h000, 0);
        req(10, 32'h1800_0000, 'h015, 0);
        // R3: load-back, out-of-range index, both bits together
        wr_reg(0, 5 | (1 << 6));
        for (int s = 0; s < 5; s++) rd_reg(s);
        wr_reg(0, 25 | (1 << 5));
        rd_reg(0); rd_reg(1);
        wr_reg(0, 25 | (1 << 6));
        rd_reg(3);
        wr_reg(0, 19 | (1 << 6));
        wr_reg(0, 2 | (1 << 5) | (1 << 6));
        rd_reg(1); rd_reg(3);
        req(3, 32'h1800_0000, 'h015, 0);
        // R9: commit in the same cycle as a request
        drv(1, 0, 7 | (1 << 5), 1, 3, 32'h1800_0000, 'h15, 0);
        req(3, 32'h1800_0000, 'h015, 0);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            int k = $urandom % 100;
            int port = $urandom % 12;
            logic [31:0] addr = {12'($urandom % 'h240), 20'($urandom)};
            int id = $urandom % 'h40;
            bit ns = 1'($urandom);
            if (k < 65) req(port, addr, id, ns);
            else if (k < 75) drv(0, $urandom % 8, 0, 1'($urandom), port, addr, id, ns);
            else if (k < 85) begin
                int sel = 1 + $urandom % 3;
                int lo = $urandom % 'h200;
                int v = (sel == 3) ? int'($urandom % 'h4000)
                                   : (((lo + $urandom % 'h80) << 12) | lo);
                if (sel == 2) v = (((($urandom % 'h20) + 'h20) << 12) | ($urandom % 'h20));
                drv(1, sel, v, 1'($urandom), port, addr, id, ns);
            end else if (k < 93)
                drv(1, 0, ($urandom % 24) | (1 << 5), 1'($urandom), port, addr, id, ns);
            else if (k < 98)
                drv(1, 0, ($urandom % 24) | (int'($urandom % 4) << 5), 1, port, addr, id, ns);
            else
                drv(1, 4, $urandom % 'h400, 1, port, addr, id, ns);
        end
        repeat (3) drv(0, 0, 0, 0, 0, 0, 0, 0);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL R8 watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule